// File: doc/BRIEF.md
# Hash Offload Command and Status Register Block

This block is the software-facing front end of a hash offload engine. A host writes the source address, destination address, key buffer address, source length and a packed command word through a simple word-addressed register port. Each register keeps only the bits that are meaningful to it. The command word is decoded when it is written. A valid algorithm selection produces a one-cycle start pulse toward the hash datapath, together with the decoded algorithm code, a scatter-gather flag and an accumulate flag. An invalid selection is flagged and does not start anything. Cascaded crypt requests and HMAC requests are flagged as unsupported.

The algorithm code has two levels. A primary field picks MD5, SHA-1, SHA-224 or SHA-256, or it opens the 512-bit family. Inside that family a second field picks the variant. When the datapath reports completion on its done input, a status flag is set whether or not interrupts are enabled. The interrupt line is raised only if the command that was last written had interrupt enable set. Software clears both the flag and the interrupt by writing a one to the flag's bit position.

Top module: `hash_cmd_regs`

## Requirements
- R1: After reset every register word reads zero, and `hash_start`, `cmd_bad`, `cmd_unsup` and `irq` are low.
- R2: Word indices are: crypt command 4, status 7, source address 8, destination address 9, key buffer 10, source length 11, hash command 12. A write keeps only these bits: source address bits [30:0]; destination and key buffer bits [30:3], with bits [2:0] read as zero; source length bits [27:0]; hash command under mask 0x00147FFF. Other in-range words keep all 32 bits.
- R3: A read returns its data one cycle after `bus_rd`. An index at or above the register count (16) reads zero, and a write to such an index changes no register.
- R4: Command bits [6:4] form the primary field and bits [12:10] the sub-select. The algorithm output encoding is: primary 000 with sub 000 gives code 0 (MD5); 010/000 gives 1 (SHA-1); 100/000 gives 2 (SHA-224); 101/000 gives 3 (SHA-256). With primary 110, sub 000 gives 4 (SHA-512), 001 gives 5 (SHA-384), 010 gives 6 (SHA-512/256) and 011 gives 7 (SHA-512/224).
- R5: Any other pairing of primary and sub-select fields is invalid. This includes a non-zero sub-select with a primary field outside the 512-bit family. An invalid command write gives a one-cycle `cmd_bad` pulse in the cycle after the write and no start pulse.
- R6: A valid command write gives `hash_start` high for exactly the one cycle after the write. `hash_sg` equals command bit 18. `hash_acc` is high only when bits [8:7] equal 10; the values 00 (plain), 01 (HMAC) and 11 (key setup) leave it low.
- R7: A command write with bit 1 set (cascaded crypt) or with bits [8:7] equal to 01 (HMAC) gives a one-cycle `cmd_unsup` pulse. A valid algorithm still starts.
- R8: `hash_done` sets status bit 9, which can be read on the cycle after, whether or not interrupts are enabled.
- R9: `irq` rises on `hash_done` only if bit 9 of the stored command word is set.
- R10: Writing the status word with bit 9 set clears the done flag and lowers `irq`. Writing it with bit 9 clear leaves both unchanged.
- R11: A write to the crypt command word is stored but never starts an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hash_done | input | 1 | Completion pulse from the hash datapath |
| hash_start | output | 1 | One-cycle start pulse |
| hash_algo | output | 3 | Decoded algorithm code |
| hash_sg | output | 1 | Scatter-gather source list |
| hash_acc | output | 1 | Accumulate mode |
| cmd_bad | output | 1 | Invalid algorithm selection pulse |
| cmd_unsup | output | 1 | Unsupported mode request pulse |
| irq | output | 1 | Interrupt line |
| src_addr | output | 32 | Stored source address |
| dst_addr | output | 32 | Stored destination address |
| key_addr | output | 32 | Stored key buffer address |
| src_len | output | 32 | Stored source length |

## Verification
On every cycle the assertions check several properties. The start pulse lasts one cycle and only follows a command write. A start never coincides with an invalid flag. Done always sets the status flag, and the interrupt only rises after a done. Out-of-range reads return zero, and the destination address stays aligned. The bench scenarios show what a property cannot: the full two-level decode table, each register's write mask, interrupt gating by the stored enable bit, and the write-one-to-clear behaviour against writes of zero.

// File: rtl/hash_regs_pkg.sv
`timescale 1ns/1ps
package hash_regs_pkg;
  localparam int WORD_W   = 32;
  localparam int ALGO_W   = 3;

  // word indices (software visible)
  localparam int IDX_CRYPT  = 4;
  localparam int IDX_STATUS = 7;
  localparam int IDX_SRC    = 8;
  localparam int IDX_DST    = 9;
  localparam int IDX_KEY    = 10;
  localparam int IDX_LEN    = 11;
  localparam int IDX_CMD    = 12;

  // bit positions that software relies on
  localparam int DONE_BIT = 9;
  localparam int IE_BIT   = 9;
  localparam int SG_BIT   = 18;
  localparam int CASC_BIT = 1;

  typedef enum logic [ALGO_W-1:0] {
    ALG_MD5       = 3'd0,
    ALG_SHA1      = 3'd1,
    ALG_SHA224    = 3'd2,
    ALG_SHA256    = 3'd3,
    ALG_SHA512    = 3'd4,
    ALG_SHA384    = 3'd5,
    ALG_SHA512_256 = 3'd6,
    ALG_SHA512_224 = 3'd7
  } hash_algo_e;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_HMAC  = 2'b01,
    MODE_ACCUM = 2'b10,
    MODE_KEY   = 2'b11
  } digest_mode_e;

  // writable bits per word; status is held outside the register file
  function automatic logic [WORD_W-1:0] reg_mask(input int idx);
    case (idx)
      IDX_SRC:          return 32'h7FFF_FFFF;
      IDX_DST, IDX_KEY: return 32'h7FFF_FFF8;
      IDX_LEN:          return 32'h0FFF_FFFF;
      IDX_CMD:          return 32'h0014_7FFF;
      IDX_STATUS:       return 32'h0000_0000;
      default:          return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/hash_cmd_decode.sv
`timescale 1ns/1ps
module hash_cmd_decode
  import hash_regs_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output logic              valid,
  output hash_algo_e        algo,
  output logic              sg,
  output logic              acc,
  output logic              unsup
);
  logic [2:0]   prim;
  logic [2:0]   sub;
  digest_mode_e mode;

  assign prim = cmd[6:4];
  assign sub  = cmd[12:10];
  assign mode = digest_mode_e'(cmd[8:7]);

  always_comb begin
    valid = 1'b1;
    algo  = ALG_MD5;
    unique case (prim)
      3'b000: algo = ALG_MD5;
      3'b010: algo = ALG_SHA1;
      3'b100: algo = ALG_SHA224;
      3'b101: algo = ALG_SHA256;
      3'b110: begin
        unique case (sub)
          3'b000:  algo = ALG_SHA512;
          3'b001:  algo = ALG_SHA384;
          3'b010:  algo = ALG_SHA512_256;
          3'b011:  algo = ALG_SHA512_224;
          default: valid = 1'b0;
        endcase
      end
      default: valid = 1'b0;
    endcase
    // sub-select only has meaning inside the 512-bit family
    if (prim != 3'b110 && sub != 3'b000) valid = 1'b0;
  end

  assign sg    = cmd[SG_BIT];
  assign acc   = (mode == MODE_ACCUM);
  assign unsup = cmd[CASC_BIT] || (mode == MODE_HMAC);
endmodule

// File: rtl/hash_reg_file.sv
`timescale 1ns/1ps
module hash_reg_file
  import hash_regs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] dst_q,
  output logic [WORD_W-1:0] key_q,
  output logic [WORD_W-1:0] len_q,
  output logic [WORD_W-1:0] cmd_q
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [WORD_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [WORD_W-1:0] MASK = reg_mask(g);
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && waddr == ADDR_W'(g)) q <= wdata & MASK;
    end
    assign regs[g] = q;
  end

  assign rword = regs[raddr[IDX_W-1:0]];
  assign src_q = regs[IDX_SRC];
  assign dst_q = regs[IDX_DST];
  assign key_q = regs[IDX_KEY];
  assign len_q = regs[IDX_LEN];
  assign cmd_q = regs[IDX_CMD];
endmodule

// File: rtl/hash_done_irq.sv
`timescale 1ns/1ps
module hash_done_irq (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic ie,
  input  logic w1c,
  output logic flag,
  output logic irq
);
  // done takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (done)     flag <= 1'b1;
      else if (w1c) flag <= 1'b0;
      if (done && ie) irq <= 1'b1;
      else if (w1c)   irq <= 1'b0;
    end
  end
endmodule

// File: rtl/hash_cmd_regs.sv
`timescale 1ns/1ps
module hash_cmd_regs
  import hash_regs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              hash_done,
  output logic              hash_start,
  output logic [ALGO_W-1:0] hash_algo,
  output logic              hash_sg,
  output logic              hash_acc,
  output logic              cmd_bad,
  output logic              cmd_unsup,
  output logic              irq,
  output logic [WORD_W-1:0] src_addr,
  output logic [WORD_W-1:0] dst_addr,
  output logic [WORD_W-1:0] key_addr,
  output logic [WORD_W-1:0] src_len
);
  localparam logic [WORD_W-1:0] CMD_MASK = reg_mask(IDX_CMD);

  logic              in_range;
  logic              wr_hit;
  logic              cmd_wr;
  logic              status_w1c;
  logic [WORD_W-1:0] rf_word;
  logic [WORD_W-1:0] cmd_q;
  logic              done_flag;
  logic [WORD_W-1:0] status_word;

  logic              dec_valid;
  hash_algo_e        dec_algo;
  logic              dec_sg;
  logic              dec_acc;
  logic              dec_unsup;

  assign in_range   = int'(bus_addr) < NUM_REGS;
  assign wr_hit     = bus_wr && in_range;
  assign cmd_wr     = wr_hit && bus_addr == ADDR_W'(IDX_CMD);
  assign status_w1c = wr_hit && bus_addr == ADDR_W'(IDX_STATUS) && bus_wdata[DONE_BIT];

  hash_reg_file #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_hit),
    .waddr (bus_addr),
    .wdata (bus_wdata),
    .raddr (bus_addr),
    .rword (rf_word),
    .src_q (src_addr),
    .dst_q (dst_addr),
    .key_q (key_addr),
    .len_q (src_len),
    .cmd_q (cmd_q)
  );

  hash_cmd_decode u_dec (
    .cmd   (bus_wdata & CMD_MASK),
    .valid (dec_valid),
    .algo  (dec_algo),
    .sg    (dec_sg),
    .acc   (dec_acc),
    .unsup (dec_unsup)
  );

  hash_done_irq u_irq (
    .clk  (clk),
    .rst  (rst),
    .done (hash_done),
    .ie   (cmd_q[IE_BIT]),
    .w1c  (status_w1c),
    .flag (done_flag),
    .irq  (irq)
  );

  always_comb begin
    status_word = '0;
    status_word[DONE_BIT] = done_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hash_start <= 1'b0;
      hash_algo  <= '0;
      hash_sg    <= 1'b0;
      hash_acc   <= 1'b0;
      cmd_bad    <= 1'b0;
      cmd_unsup  <= 1'b0;
    end else begin
      hash_start <= cmd_wr && dec_valid;
      cmd_bad    <= cmd_wr && !dec_valid;
      cmd_unsup  <= cmd_wr && dec_unsup;
      if (cmd_wr && dec_valid) begin
        hash_algo <= dec_algo;
        hash_sg   <= dec_sg;
        hash_acc  <= dec_acc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (!in_range)                            bus_rdata <= '0;
      else if (bus_addr == ADDR_W'(IDX_STATUS)) bus_rdata <= status_word;
      else                                      bus_rdata <= rf_word;
    end
  end
endmodule

// File: rtl/hash_cmd_regs_chk.sv
`timescale 1ns/1ps
module hash_cmd_regs_chk
  import hash_regs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              hash_done,
  input logic              hash_start,
  input logic              cmd_bad,
  input logic              irq,
  input logic [WORD_W-1:0] dst_addr,
  input logic              done_flag
);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    hash_start |=> !hash_start);

  assert_start_cause_R6: assert property (@(posedge clk) disable iff (rst)
    hash_start |-> $past(bus_wr && bus_addr == ADDR_W'(IDX_CMD)));

  assert_bad_no_start_R5: assert property (@(posedge clk) disable iff (rst)
    !(hash_start && cmd_bad));

  assert_done_sets_R8: assert property (@(posedge clk) disable iff (rst)
    hash_done |=> done_flag);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(hash_done));

  assert_oob_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) >= NUM_REGS) |=> bus_rdata == '0);

  assert_dst_align_R2: assert property (@(posedge clk) disable iff (rst)
    dst_addr[2:0] == 3'b000);
endmodule

bind hash_cmd_regs hash_cmd_regs_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .hash_done (hash_done),
  .hash_start(hash_start),
  .cmd_bad   (cmd_bad),
  .irq       (irq),
  .dst_addr  (dst_addr),
  .done_flag (done_flag)
);

// File: tb/tb_hash_cmd_regs.sv
`timescale 1ns/1ps
module tb_hash_cmd_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hash_done = 1'b0;
  logic        hash_start;
  logic [2:0]  hash_algo;
  logic        hash_sg, hash_acc, cmd_bad, cmd_unsup, irq;
  logic [31:0] src_addr, dst_addr, key_addr, src_len;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #2.5 clk = ~clk;

  hash_cmd_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hash_done(hash_done),
    .hash_start(hash_start), .hash_algo(hash_algo), .hash_sg(hash_sg),
    .hash_acc(hash_acc), .cmd_bad(cmd_bad), .cmd_unsup(cmd_unsup), .irq(irq),
    .src_addr(src_addr), .dst_addr(dst_addr), .key_addr(key_addr), .src_len(src_len)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one read result per read strobe, one cycle later
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); hash_done = 1'b1;
    @(negedge clk); hash_done = 1'b0;
  endtask

  // model of the command decode, built from R4..R7
  task automatic issue(input logic [31:0] c, input string tag);
    logic [2:0] p = c[6:4];
    logic [2:0] s = c[12:10];
    logic ok = 1'b1;
    logic [2:0] a = 3'd0;
    if      (p == 3'b000 && s == 3'b000) a = 3'd0;
    else if (p == 3'b010 && s == 3'b000) a = 3'd1;
    else if (p == 3'b100 && s == 3'b000) a = 3'd2;
    else if (p == 3'b101 && s == 3'b000) a = 3'd3;
    else if (p == 3'b110 && s <= 3'b011) a = 3'd4 + s;
    else ok = 1'b0;
    wr(12, c);
    check({tag, " R6 start"}, 32'(hash_start), 32'(ok));
    check({tag, " R5 bad"}, 32'(cmd_bad), 32'(!ok));
    check({tag, " R7 unsup"}, 32'(cmd_unsup), 32'(c[1] || c[8:7] == 2'b01));
    if (ok) begin
      check({tag, " R4 algo"}, 32'(hash_algo), 32'(a));
      check({tag, " R6 sg"}, 32'(hash_sg), 32'(c[18]));
      check({tag, " R6 acc"}, 32'(hash_acc), 32'(c[8:7] == 2'b10));
    end
    @(negedge clk);
    check({tag, " R6 single pulse"}, 32'(hash_start), 32'd0);
    check({tag, " R5 single bad"}, 32'(cmd_bad), 32'd0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 start", 32'(hash_start), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 bad", 32'(cmd_bad), 0);
    check("R1 unsup", 32'(cmd_unsup), 0);
    for (int i = 0; i < 16; i++) rd(i, 32'd0, $sformatf("R1 reset word %0d", i));

    // R2 masks
    wr(8, 32'hFFFF_FFFF);  rd(8, 32'h7FFF_FFFF, "R2 src mask");
    wr(9, 32'hFFFF_FFFF);  rd(9, 32'h7FFF_FFF8, "R2 dst mask");
    wr(10, 32'hFFFF_FFFF); rd(10, 32'h7FFF_FFF8, "R2 key mask");
    wr(11, 32'hFFFF_FFFF); rd(11, 32'h0FFF_FFFF, "R2 len mask");
    check("R2 dst port", dst_addr, 32'h7FFF_FFF8);
    check("R2 len port", src_len, 32'h0FFF_FFFF);
    wr(5, 32'hA5A5_A5A5);  rd(5, 32'hA5A5_A5A5, "R2 plain word");
    issue(32'hFFFF_FFFF, "R5 all ones cmd");
    rd(12, 32'h0014_7FFF, "R2 cmd mask");

    // R3 out of range
    wr(16 + 8, 32'h1234_5678);
    rd(8, 32'h7FFF_FFFF, "R3 oob write ignored");
    rd(24, 32'd0, "R3 oob read");
    rd(200, 32'd0, "R3 oob read high");

    // R4 decode table
    issue(32'h0000_0000, "R4 md5");
    issue(32'h0000_0020, "R4 sha1");
    issue(32'h0000_0040, "R4 sha224");
    issue(32'h0000_0050, "R4 sha256");
    issue(32'h0000_0060, "R4 sha512");
    issue(32'h0000_0460, "R4 sha384");
    issue(32'h0000_0860, "R4 sha512_256");
    issue(32'h0000_0C60, "R4 sha512_224");
    // R5 invalid selections
    issue(32'h0000_0070, "R5 prim 111");
    issue(32'h0000_0010, "R5 prim 001");
    issue(32'h0000_0030, "R5 prim 011");
    issue(32'h0000_1060, "R5 sub 100");
    issue(32'h0000_0420, "R5 sub outside family");
    // R6 flags and modes
    issue(32'h0004_0120, "R6 sg acc");
    issue(32'h0000_0180, "R6 key mode no acc");
    // R7 unsupported
    issue(32'h0000_00A0, "R7 hmac");
    issue(32'h0000_0002, "R7 cascaded");

    // R11 crypt command
    wr(4, 32'h0000_0060);
    check("R11 crypt no start", 32'(hash_start), 0);
    rd(4, 32'h0000_0060, "R11 crypt stored");

    // R8 done without interrupt enable
    issue(32'h0000_0020, "R8 cmd ie off");
    pulse_done();
    check("R9 irq gated off", 32'(irq), 0);
    rd(7, 32'h0000_0200, "R8 done flag no ie");
    // R10 write zero keeps, write one clears
    wr(7, 32'h0000_0000);
    rd(7, 32'h0000_0200, "R10 write zero keeps");
    wr(7, 32'h0000_0200);
    rd(7, 32'h0000_0000, "R10 w1c clears");

    // R9 interrupt with enable
    issue(32'h0000_0220, "R9 cmd ie on");
    check("R9 irq before done", 32'(irq), 0);
    pulse_done();
    check("R9 irq raised", 32'(irq), 1);
    rd(7, 32'h0000_0200, "R8 done flag ie");
    wr(7, 32'h0000_0000);
    check("R10 irq kept", 32'(irq), 1);
    wr(7, 32'h0000_0200);
    check("R10 irq lowered", 32'(irq), 0);
    rd(7, 32'h0000_0000, "R10 flag cleared");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule